// File: doc/BRIEF.md
# Self-Repairing Carry-Select Adder with Spare Cells

This block is a wide binary adder that keeps producing correct results after individual full-adder cells fail. The word is cut into equal slices. Inside a slice the carry ripples from cell to cell, and each slice works out its result for both possible incoming carries at once. The real carry from the slice below then picks one of the two answers, as in a carry-select adder. Every slice has one cell more than it has bit positions. The extra cell stays powered and wired, ready to take over.

Each cell works out its carry twice, once with the ripple form and once with the majority form, and compares the two. When the two disagree, the cell's location is latched at the next rising clock. From then on, the slice's sum and carry steering routes each bit position past the failed cell, and the bits above it move up by one cell. The adder never stops. If a slice collects a second failed cell, it can no longer be repaired, and a global flag is raised. A per-cell stuck-at injection port lets a test environment force faults.

Top module: `sra_adder`

## Requirements
- R1: With no fault latched and no cell disagreeing, {cout, sum} equals a + b + cin for every operand pair.
- R2: When a cell's injection enable is high and the forced carry value differs from the true carry, the cell's fault_loc bit is still 0 before the next rising clock and is 1 after it. Cell j of slice k has bit k*(BLKW+1)+j, and the spare is cell index BLKW.
- R3: A latched fault_loc bit stays at 1 after its injection is removed, until reset.
- R4: With exactly one latched fault in a slice, including a fault in the spare, {cout, sum} equals a + b + cin for all operands, even while the faulty cell stays forced, and unrecov stays 0.
- R5: Single faults in different slices are latched together, each at its own bit, and the sum stays correct with unrecov at 0.
- R6: A second latched fault in the same slice sets unrecov at the rising clock that latches it.
- R7: Asserting rst_n clears fault_loc and unrecov at once.
- R8: A forced carry value that matches the cell's true carry raises no fault, and fault_loc stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fault latches |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a | input | NBLK*BLKW | First operand |
| b | input | NBLK*BLKW | Second operand |
| cin | input | 1 | Carry into bit 0 |
| inj_en | input | NBLK*(BLKW+1) | Per-cell enable that forces the cell's carry outputs |
| inj_val | input | NBLK*(BLKW+1) | Per-cell value the forced carry takes |
| sum | output | NBLK*BLKW | Sum, combinational from operands and latched repair state |
| cout | output | 1 | Carry out of the top slice |
| fault_loc | output | NBLK*(BLKW+1) | Latched faulty-cell map |
| unrecov | output | 1 | Some slice holds more faulty cells than spares |

## Verification
The bench builds the adder with two slices of four bits each: an 8-bit word over ten physical cells. At that size every operand pair and both carry-in values can be swept with no fault present. Every one of the ten cells, the spares included, can be failed in turn and the repaired adder swept over a dense operand grid while the fault stays forced. The same small setup makes it cheap to pair two faults in one slice, split faults across slices, and force a value that matches the true carry.

// File: rtl/sra_pkg.sv
package sra_pkg;
  // Two-rail value: index 0 assumes slice carry-in 0, index 1 assumes 1.
  typedef logic [1:0] rail_t;

  localparam rail_t RAIL_SEED = 2'b10;
endpackage

// File: rtl/sra_cell.sv
module sra_cell
  import sra_pkg::*;
(
  input  logic  a,
  input  logic  b,
  input  rail_t ci,
  input  logic  stuck_en,
  input  logic  stuck_v,
  output rail_t s,
  output rail_t co,
  output logic  err
);
  rail_t c_ripple;
  rail_t c_major;

  always_comb begin
    err = 1'b0;
    for (int r = 0; r < 2; r++) begin
      c_ripple[r] = (a & b) | (ci[r] & (a ^ b));
      c_major[r]  = (a & b) | (a & ci[r]) | (b & ci[r]);
      s[r]        = a ^ b ^ ci[r];
      co[r]       = stuck_en ? stuck_v : c_ripple[r];
      err         = err | (co[r] ^ c_major[r]);
    end
  end
endmodule

// File: rtl/sra_slice.sv
module sra_slice
  import sra_pkg::*;
#(
  parameter int BLKW = 8,
  localparam int NC = BLKW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BLKW-1:0] a,
  input  logic [BLKW-1:0] b,
  input  logic [NC-1:0]   inj_en,
  input  logic [NC-1:0]   inj_val,
  output logic [BLKW-1:0] sum0,
  output logic [BLKW-1:0] sum1,
  output rail_t           co,
  output logic [NC-1:0]   fault,
  output logic            bad,
  output logic            fresh
);
  logic [NC-1:0] fault_q;
  logic [NC-1:0] fault_d;
  logic [NC-1:0] err;
  logic [NC-1:0] below;
  logic          lat_en;

  // below[j]: some cell with index < j has a latched fault
  always_comb begin
    below[0] = 1'b0;
    for (int j = 1; j < NC; j++) begin
      below[j] = below[j-1] | fault_q[j-1];
    end
  end

  for (genvar j = 0; j < NC; j++) begin : g_cell
    logic  a_l;
    logic  b_l;
    rail_t ci_l;
    rail_t s_l;
    rail_t co_l;
    logic  err_l;

    if (j == 0) begin : g_first
      assign a_l  = a[0];
      assign b_l  = b[0];
      assign ci_l = RAIL_SEED;
    end else begin : g_rest
      if (j == BLKW) begin : g_spare
        assign a_l = a[BLKW-1];
        assign b_l = b[BLKW-1];
      end else begin : g_mid
        assign a_l = below[j] ? a[j-1] : a[j];
        assign b_l = below[j] ? b[j-1] : b[j];
      end
      // carry bypass around a failed neighbour
      assign ci_l = fault_q[j-1] ? g_cell[j-1].ci_l : g_cell[j-1].co_l;
    end

    sra_cell u_cell (
      .a        (a_l),
      .b        (b_l),
      .ci       (ci_l),
      .stuck_en (inj_en[j]),
      .stuck_v  (inj_val[j]),
      .s        (s_l),
      .co       (co_l),
      .err      (err_l)
    );

    assign err[j] = err_l;
  end

  // sum bypass: bit i moves up one cell once any cell at or below i failed
  for (genvar i = 0; i < BLKW; i++) begin : g_sum
    assign sum0[i] = below[i+1] ? g_cell[i+1].s_l[0] : g_cell[i].s_l[0];
    assign sum1[i] = below[i+1] ? g_cell[i+1].s_l[1] : g_cell[i].s_l[1];
  end

  assign co     = below[BLKW] ? g_cell[BLKW].co_l : g_cell[BLKW-1].co_l;
  assign bad    = |(fault_q & below);
  assign fresh  = |(err & ~fault_q);
  assign fault  = fault_q;

  // next-state
  always_comb begin
    lat_en  = fresh;
    fault_d = fault_q | err;
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= '0;
    end else if (lat_en) begin
      fault_q <= fault_d;
    end
  end

  // R2: a disagreeing cell is located at the next edge
  assert_locate_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (err != '0) |=> ((fault_q & $past(err)) == $past(err)));

  // R3: a located cell stays located
  assert_sticky_loc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q != '0) |=> ((fault_q & $past(fault_q)) == $past(fault_q)));
endmodule

// File: rtl/sra_adder.sv
module sra_adder
  import sra_pkg::*;
#(
  parameter int NBLK = 8,
  parameter int BLKW = 8,
  localparam int W     = NBLK * BLKW,
  localparam int NC    = BLKW + 1,
  localparam int NCELL = NBLK * NC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic             cin,
  input  logic [NCELL-1:0] inj_en,
  input  logic [NCELL-1:0] inj_val,
  output logic [W-1:0]     sum,
  output logic             cout,
  output logic [NCELL-1:0] fault_loc,
  output logic             unrecov
);
  logic            rst_s0;
  logic            rst_s1;
  logic            rst_q_n;
  logic [NBLK-1:0] bad_v;
  logic [NBLK-1:0] fresh_v;
  logic            fresh_any;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end
  assign rst_q_n = rst_s1 & rst_n;

  for (genvar k = 0; k < NBLK; k++) begin : g_blk
    logic [BLKW-1:0] s0_l;
    logic [BLKW-1:0] s1_l;
    rail_t           co_l;
    logic            cin_l;
    logic            cout_l;

    if (k == 0) begin : g_lo
      assign cin_l = cin;
    end else begin : g_hi
      assign cin_l = g_blk[k-1].cout_l;
    end

    sra_slice #(.BLKW(BLKW)) u_slice (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .a       (a[k*BLKW +: BLKW]),
      .b       (b[k*BLKW +: BLKW]),
      .inj_en  (inj_en[k*NC +: NC]),
      .inj_val (inj_val[k*NC +: NC]),
      .sum0    (s0_l),
      .sum1    (s1_l),
      .co      (co_l),
      .fault   (fault_loc[k*NC +: NC]),
      .bad     (bad_v[k]),
      .fresh   (fresh_v[k])
    );

    // carry-select between the two precomputed rails
    assign sum[k*BLKW +: BLKW] = cin_l ? s1_l : s0_l;
    assign cout_l              = cin_l ? co_l[1] : co_l[0];

    // R6: two located cells in one slice cannot be repaired
    assert_two_faults_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
      ($countones(fault_loc[k*NC +: NC]) > 1) |-> unrecov);
  end

  assign cout      = g_blk[NBLK-1].cout_l;
  assign unrecov   = |bad_v;
  assign fresh_any = |fresh_v;

  // R1: arithmetic result whenever every slice is healthy or repaired
  assert_sum_ok_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!unrecov && !fresh_any) |->
      ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin})));
endmodule

// File: tb/sra_adder_test.sv
module sra_adder_test;
  localparam int NBLK  = 2;
  localparam int BLKW  = 4;
  localparam int W     = NBLK * BLKW;
  localparam int NC    = BLKW + 1;
  localparam int NCELL = NBLK * NC;
  localparam int TCLK  = 10;

  logic             clk;
  logic             rst_n;
  logic [W-1:0]     a;
  logic [W-1:0]     b;
  logic             cin;
  logic [NCELL-1:0] inj_en;
  logic [NCELL-1:0] inj_val;
  logic [W-1:0]     sum;
  logic             cout;
  logic [NCELL-1:0] fault_loc;
  logic             unrecov;

  int nchk;
  int nbad;

  sra_adder #(.NBLK(NBLK), .BLKW(BLKW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .a         (a),
    .b         (b),
    .cin       (cin),
    .inj_en    (inj_en),
    .inj_val   (inj_val),
    .sum       (sum),
    .cout      (cout),
    .fault_loc (fault_loc),
    .unrecov   (unrecov)
  );

  initial begin
    clk = 1'b0;
    forever #(TCLK/2) clk = ~clk;
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input int av, input int bv, input int cv);
    a   = av[W-1:0];
    b   = bv[W-1:0];
    cin = cv[0];
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    inj_en  = '0;
    inj_val = '0;
    drive(0, 0, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic sweep(input int bstep, input string tag);
    for (int x = 0; x < (1 << W); x++) begin
      for (int y = 0; y < (1 << W); y += bstep) begin
        for (int c = 0; c < 2; c++) begin
          int e;
          drive(x, y, c);
          #1;
          e = x + y + c;
          chk({cout, sum} == e[W:0], tag, longint'({cout, sum}), longint'(e[W:0]));
          #1;
        end
      end
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    nchk = 0;
    nbad = 0;
    do_reset();
    #1;
    chk(fault_loc == '0, "R7 reset map", longint'(fault_loc), 0);
    chk(unrecov == 1'b0, "R7 reset flag", longint'(unrecov), 0);

    // R1: full sweep with no faults
    sweep(1, "R1 fault-free sum");

    // R8: forced value equals true carry (zero operands, stuck at 0)
    do_reset();
    inj_en[3] = 1'b1;
    inj_val   = '0;
    drive(0, 0, 0);
    repeat (3) @(negedge clk);
    #1;
    chk(fault_loc == '0, "R8 no false fault", longint'(fault_loc), 0);
    chk({cout, sum} == '0, "R8 sum", longint'({cout, sum}), 0);

    // R2, R4, R3, R6 for every physical cell
    for (int c = 0; c < NCELL; c++) begin
      int blk;
      int c2;
      logic [NCELL-1:0] one;
      logic [NCELL-1:0] two;
      blk = c / NC;
      c2  = blk * NC + ((c % NC) + 2) % NC;
      one = '0;
      one[c] = 1'b1;
      two = one;
      two[c2] = 1'b1;
      do_reset();
      @(negedge clk);
      inj_en  = one;
      inj_val = one;
      drive(0, 0, 0);
      #1;
      chk(fault_loc == '0, "R2 not before edge", longint'(fault_loc), 0);
      @(negedge clk);
      #1;
      chk(fault_loc == one, "R2 located", longint'(fault_loc), longint'(one));
      chk(unrecov == 1'b0, "R4 single fault recoverable", longint'(unrecov), 0);
      sweep(5, "R4 repaired sum");
      @(negedge clk);
      inj_en  = '0;
      inj_val = '0;
      @(negedge clk);
      #1;
      chk(fault_loc == one, "R3 sticky", longint'(fault_loc), longint'(one));
      @(negedge clk);
      inj_en  = two;
      inj_val = two;
      drive(0, 0, 0);
      @(negedge clk);
      #1;
      chk(unrecov == 1'b1, "R6 second fault", longint'(unrecov), 1);
      chk(fault_loc == two, "R6 both located", longint'(fault_loc), longint'(two));
    end

    // R5: one fault in each slice
    do_reset();
    begin
      logic [NCELL-1:0] pair;
      pair = '0;
      pair[1] = 1'b1;
      pair[NC + BLKW - 1] = 1'b1;
      inj_en  = pair;
      inj_val = pair;
      drive(0, 0, 0);
      @(negedge clk);
      #1;
      chk(fault_loc == pair, "R5 both slices located", longint'(fault_loc), longint'(pair));
      chk(unrecov == 1'b0, "R5 still recoverable", longint'(unrecov), 0);
      sweep(3, "R5 repaired sum");
    end

    // R7: asynchronous clear
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(fault_loc == '0, "R7 clear map", longint'(fault_loc), 0);
    chk(unrecov == 1'b0, "R7 clear flag", longint'(unrecov), 0);
    inj_en  = '0;
    inj_val = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule